// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder with Refresh Counter

This block is a clocked model of the control side of a sixteen-bit extended-data-out DRAM. It samples an active-low row strobe, one active-low column strobe per byte lane, a write enable, an output enable and a shared address bus on every clock edge. From these it latches the row and column addresses, raises per-lane write pulses and drives read data out of a small internal array. It also keeps an internal refresh row counter.

The active column strobe is the wired-OR of the lane strobes. It starts when the first lane strobe falls and ends only when the last one rises. The row strobe falls once per cycle, and the order of the two strobes sets the kind of cycle. If the row strobe falls with the column strobe inactive, the cycle is a normal access or a row-only refresh. If a column strobe is already active when the row strobe falls, the cycle is a counter-driven refresh, and this also covers hidden refresh.

Read data stays on the bus between column strobes, in the extended-data-out manner. The block is meant to be the device under test when a DRAM controller is checked. Every strobe edge is seen one clock after the input changes, and the row strobe must fall at least one clock before the first column strobe of an access.

Top module: `edo_strobe_decoder`

## Requirements
- R1: The column address is latched from `addr` when the first lane strobe falls while an access is open. A second lane strobe falling, or one lane rising and falling again while another lane stays low, does not change `col_q`.
- R2: On every row-strobe falling edge with no lane strobe low, `row_q` takes the value of `addr`. `row_q` changes at no other time except in R4.
- R3: In a write, a lane is written only when its own strobe falls. Lane 0 (`cas_n[0]`) covers data bits 7:0 and lane 1 (`cas_n[1]`) covers bits 15:8. A lane whose strobe stays high keeps its stored byte. `wr_lane` bit i pulses for one clock after lane i is written.
- R4: If any lane strobe is low when the row strobe falls, the cycle is a refresh. `row_q` takes the refresh counter value, and the counter then increments. During this refresh no lane is written and `col_q` does not change.
- R5: A row strobe cycle with no column strobe latches the row from `addr`. It does not change the refresh counter, `col_q` or the data output.
- R6: Hidden refresh: the column strobe stays low after a read while the row strobe rises and then falls again. This runs an R4 refresh, and the read data stays driven with the same value.
- R7: Read data is fetched on each column-strobe falling edge with `we_n` high, one clock after the edge. It stays driven after the column strobe rises, until the next fetch replaces it.
- R8: `dout_en` drops at once when `oe_n` goes high and comes back when `oe_n` returns low. The held data is released one clock after both the row strobe and the column strobe are inactive.
- R9: The refresh counter is 9 bits wide, reads 0 after reset and wraps from 511 to 0.
- R10: The data output is not enabled while a write pulse is active.
- R11: After reset, `dout_en`, `wr_lane`, `row_q`, `col_q` and `ref_row` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Column strobe per byte lane, active low, bit 0 is the low byte |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Shared row and column address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data |
| dout_en | output | 1 | Data output drive enable |
| row_q | output | 9 | Latched row address |
| col_q | output | 9 | Latched column address |
| wr_lane | output | 2 | Per-lane write pulse |
| ref_row | output | 9 | Refresh row counter |

## Verification
The bench uses the default parameters: a 9-bit address, two 8-bit lanes, and an array of eight rows by eight columns. With the full 9-bit counter, the wrap from 511 to 0 takes only about two thousand clocks, so the bench reaches it with back-to-back counter refreshes. The small array lets byte merges and page reads be predicted from a 64-word model kept in the bench.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ACCESS = 2'd1,
        CYC_CBR    = 2'd2
    } cyc_e;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_low;
    } strb_ev_t;

endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync
    import dram_ctl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic [LANES-1:0] lane_n,
    output strb_ev_t         ev,
    output logic [LANES-1:0] lane_fall
);

    logic             ras_q;
    logic [LANES-1:0] lane_q;
    logic             cas_low_now;
    logic             cas_low_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q  <= 1'b1;
            lane_q <= '1;
        end else begin
            ras_q  <= ras_n;
            lane_q <= lane_n;
        end
    end

    // effective column strobe: first lane down, last lane up
    assign cas_low_now  = ~&lane_n;
    assign cas_low_prev = ~&lane_q;

    always_comb begin
        ev.ras_fall = ras_q & ~ras_n;
        ev.ras_rise = ~ras_q & ras_n;
        ev.cas_fall = ~cas_low_prev & cas_low_now;
        ev.cas_low  = cas_low_now;
    end

    assign lane_fall = lane_q & ~lane_n;

endmodule

// File: rtl/dram_row_ctl.sv
module dram_row_ctl
    import dram_ctl_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  strb_ev_t          ev,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] ref_row,
    output cyc_e              cyc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q   <= '0;
            ref_row <= '0;
            cyc     <= CYC_IDLE;
        end else if (ev.ras_fall) begin
            if (ev.cas_low) begin
                row_q   <= ref_row;
                ref_row <= ref_row + 1'b1;
                cyc     <= CYC_CBR;
            end else begin
                row_q <= addr;
                cyc   <= CYC_ACCESS;
            end
        end else if (ev.ras_rise) begin
            cyc <= CYC_IDLE;
        end
    end

    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        (ev.ras_fall && ev.cas_low) |=> ref_row == $past(ref_row) + 1'b1); // R4
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ev.ras_fall && ev.cas_low) |=> ref_row == $past(ref_row)); // R5
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ev.ras_fall |=> row_q == $past(row_q)); // R2

endmodule

// File: rtl/dram_lane_array.sv
module dram_lane_array #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        wr_en,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en[l])
                mem[idx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= mem[idx];
    end

endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
    import dram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int LANES    = 2,
    parameter int LANE_W   = 8,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ras_n,
    input  logic [LANES-1:0]        cas_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en,
    output logic [ADDR_W-1:0]       row_q,
    output logic [ADDR_W-1:0]       col_q,
    output logic [LANES-1:0]        wr_lane,
    output logic [ADDR_W-1:0]       ref_row
);

    localparam int IDX_W = ROW_BITS + COL_BITS;

    strb_ev_t          ev;
    logic [LANES-1:0]  lane_fall;
    cyc_e              cyc;
    logic              fetch;
    logic              rd_en;
    logic [LANES-1:0]  wr_next;
    logic [COL_BITS-1:0] col_lo;
    logic [IDX_W-1:0]  idx;
    logic              valid;

    dram_strobe_sync #(.LANES(LANES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ras_n     (ras_n),
        .lane_n    (cas_n),
        .ev        (ev),
        .lane_fall (lane_fall)
    );

    dram_row_ctl #(.ADDR_W(ADDR_W)) u_row (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .addr    (addr),
        .row_q   (row_q),
        .ref_row (ref_row),
        .cyc     (cyc)
    );

    assign fetch  = ev.cas_fall && (cyc == CYC_ACCESS);
    assign rd_en  = fetch && we_n;
    assign col_lo = fetch ? addr[COL_BITS-1:0] : col_q[COL_BITS-1:0];
    assign idx    = {row_q[ROW_BITS-1:0], col_lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_next[g] = lane_fall[g] && (cyc == CYC_ACCESS) && !we_n;

        AST_LANE_STROBE: assert property (@(posedge clk) disable iff (rst)
            wr_lane[g] |-> !$past(cas_n[g])); // R3
    end

    dram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_next),
        .rd_en (rd_en),
        .idx   (idx),
        .wdata (din),
        .rdata (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            wr_lane <= '0;
            valid   <= 1'b0;
        end else begin
            wr_lane <= wr_next;
            if (fetch)
                col_q <= addr;
            if (rd_en)
                valid <= 1'b1;
            else if ((|wr_next) || (ras_n && !ev.cas_low))
                valid <= 1'b0;
        end
    end

    assign dout_en = valid && !oe_n;

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|wr_lane) |-> !dout_en); // R10
    AST_EDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd_en) |=> $stable(dout)); // R7
    AST_CBR_NO_COLUMN: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_CBR) |=> $stable(col_q)); // R4

endmodule

// File: tb/sim_edo_strobe_decoder.sv
`timescale 1ns/1ps
module sim_edo_strobe_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1;
    logic [1:0]  cas_n = 2'b11;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en;
    logic [8:0]  row_q, col_q, ref_row;
    logic [1:0]  wr_lane;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    edo_strobe_decoder u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .row_q(row_q), .col_q(col_q), .wr_lane(wr_lane), .ref_row(ref_row)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic close_all();
        cas_n = 2'b11; ras_n = 1'b1; we_n = 1'b1;
        step(); step();
    endtask

    task automatic open_row(input logic [8:0] r);
        addr = r; ras_n = 1'b0; step();
    endtask

    task automatic write_word(input logic [8:0] r, input logic [8:0] c, input logic [15:0] d);
        open_row(r);
        addr = c; din = d; we_n = 1'b0; cas_n = 2'b00; step();
        close_all();
    endtask

    task automatic t_reset();
        check(dout_en == 1'b0, "R11 dout_en", dout_en, 0);
        check(wr_lane == 2'b00, "R11 wr_lane", wr_lane, 0);
        check(row_q == 9'd0 && col_q == 9'd0, "R11 row/col", {row_q, col_q}, 0);
        check(ref_row == 9'd0, "R11 R9 ref_row", ref_row, 0);
    endtask

    task automatic t_row_latch();
        open_row(9'h1A5);
        check(row_q == 9'h1A5, "R2 row latch", row_q, 9'h1A5);
        step();
        check(row_q == 9'h1A5, "R2 row held", row_q, 9'h1A5);
        close_all();
    endtask

    task automatic t_byte_write();
        open_row(9'd2);
        addr = 9'd3; din = 16'hBEEF; we_n = 1'b0; cas_n = 2'b00; step();
        check(wr_lane == 2'b11, "R3 word write pulse", wr_lane, 3);
        check(col_q == 9'd3, "R1 column latch", col_q, 3);
        close_all();
        open_row(9'd2);
        addr = 9'd3; din = 16'h1234; we_n = 1'b0; cas_n = 2'b01; step();
        check(wr_lane == 2'b10, "R3 upper lane only", wr_lane, 2);
        close_all();
        open_row(9'd2);
        addr = 9'd3; cas_n = 2'b00; step();
        check(dout_en && dout == 16'h12EF, "R3 merged byte", dout, 16'h12EF);
        close_all();
    endtask

    task automatic t_first_last();
        open_row(9'd4);
        addr = 9'd5; din = 16'h11AA; we_n = 1'b0; cas_n = 2'b10; step();
        check(col_q == 9'd5 && wr_lane == 2'b01, "R1 first strobe", {col_q, wr_lane}, {9'd5, 2'b01});
        addr = 9'd6; din = 16'h5533; cas_n = 2'b00; step();
        check(col_q == 9'd5, "R1 second strobe ignored", col_q, 5);
        check(wr_lane == 2'b10, "R3 late lane write", wr_lane, 2);
        we_n = 1'b1; addr = 9'd7; cas_n = 2'b01; step();
        cas_n = 2'b00; step();
        check(col_q == 9'd5, "R1 no new column while one lane low", col_q, 5);
        close_all();
        open_row(9'd4);
        addr = 9'd5; cas_n = 2'b00; step();
        check(dout_en && dout == 16'h55AA, "R3 R1 stored word", dout, 16'h55AA);
        close_all();
    endtask

    task automatic t_edo();
        write_word(9'd1, 9'd0, 16'h0101);
        write_word(9'd1, 9'd1, 16'h0202);
        open_row(9'd1);
        addr = 9'd0; cas_n = 2'b00; step();
        check(dout_en && dout == 16'h0101, "R7 first fetch", dout, 16'h0101);
        cas_n = 2'b11; step();
        check(dout_en && dout == 16'h0101, "R7 held after column rise", dout, 16'h0101);
        addr = 9'd1; cas_n = 2'b00; step();
        check(dout_en && dout == 16'h0202, "R7 next fetch", dout, 16'h0202);
        oe_n = 1'b1; #1;
        check(!dout_en, "R8 oe release", dout_en, 0);
        oe_n = 1'b0; #1;
        check(dout_en && dout == 16'h0202, "R8 oe return", dout, 16'h0202);
        step();
        cas_n = 2'b11; step();
        addr = 9'd2; din = 16'h0303; we_n = 1'b0; cas_n = 2'b00; step();
        check(wr_lane == 2'b11 && !dout_en, "R10 no drive in write", dout_en, 0);
        cas_n = 2'b11; we_n = 1'b1; step();
        addr = 9'd1; cas_n = 2'b00; step();
        check(dout_en, "R8 drive before close", dout_en, 1);
        cas_n = 2'b11; ras_n = 1'b1; step();
        check(!dout_en, "R8 release on both strobes high", dout_en, 0);
        step();
    endtask

    task automatic t_ras_only();
        logic [8:0] r0, c0;
        r0 = ref_row; c0 = col_q;
        open_row(9'h077); step(); step();
        check(row_q == 9'h077, "R5 row from pins", row_q, 9'h077);
        check(ref_row == r0, "R5 counter unchanged", ref_row, r0);
        check(col_q == c0 && !dout_en, "R5 no column, no drive", col_q, c0);
        close_all();
    endtask

    task automatic t_cbr();
        logic [8:0] r0, c0;
        r0 = ref_row; c0 = col_q;
        we_n = 1'b0; addr = 9'h0AA; cas_n = 2'b00; step();
        ras_n = 1'b0; step();
        check(row_q == r0, "R4 row from counter", row_q, r0);
        check(ref_row == r0 + 9'd1, "R4 counter step", ref_row, r0 + 9'd1);
        step();
        check(wr_lane == 2'b00 && col_q == c0, "R4 no write no column", {wr_lane, col_q}, {2'b00, c0});
        close_all();
    endtask

    task automatic t_hidden();
        logic [8:0] r0;
        open_row(9'd1);
        addr = 9'd1; cas_n = 2'b00; step();
        check(dout_en && dout == 16'h0202, "R6 read before hide", dout, 16'h0202);
        r0 = ref_row;
        ras_n = 1'b1; step();
        ras_n = 1'b0; step();
        check(dout_en && dout == 16'h0202, "R6 data kept", dout, 16'h0202);
        check(ref_row == r0 + 9'd1 && row_q == r0, "R6 refresh done", ref_row, r0 + 9'd1);
        close_all();
        check(!dout_en, "R8 R6 release after hidden", dout_en, 0);
    endtask

    task automatic t_wrap();
        bit saw_zero;
        saw_zero = 1'b0;
        for (int i = 0; i < 600 && !saw_zero; i++) begin
            cas_n = 2'b00; step();
            ras_n = 1'b0; step();
            if (ref_row == 9'd0) saw_zero = 1'b1;
            ras_n = 1'b1; step();
            cas_n = 2'b11; step();
        end
        check(saw_zero, "R9 wrap 511 to 0", ref_row, 0);
        check(row_q == 9'd511, "R9 last row before wrap", row_q, 511);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_row_latch();
        t_byte_write();
        t_first_last();
        t_edo();
        t_ras_only();
        t_cbr();
        t_hidden();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule